// File: doc/BRIEF.md
# Memory Dependence Tracking Unit

This block sits beside the issue queue of an out-of-order core and decides when each in-flight load or store may be handed to the memory pipeline. Every memory operation, and every memory barrier, gets an entry in a small table. The entry is tagged with its sequence number and thread. It records whether the source registers are ready, whether any memory ordering constraint is still pending, and which older store or barrier it waits on.

A single command port carries one operation per cycle. The operations are insert, register-ready notification, completion, reschedule, replay and squash. A predictor outside the block supplies, with each insert, the sequence number of the store the new operation is predicted to depend on, or zero. Barriers that are still outstanding take precedence over that prediction. Operations that become issuable are presented one at a time on a valid/ready output, oldest first.

Top module: `memdep_tracker`

## Requirements
- R1: After reset the ready output is invalid, and the full flag and error flag are both low.
- R2: Command codes on cmd_op are 0 idle, 1 insert, 2 registers-ready, 3 complete, 4 reschedule, 5 replay and 6 squash. Kind codes on cmd_kind are 0 load, 1 store, 2 full barrier and 3 write barrier. An inserted load or store with no producer is memory-ready, and if cmd_regs_ready was set it is offered on the ready output from the next cycle. There is no producer when the selected producer number is zero or does not name a live store or barrier; a number naming a load counts as none.
- R3: An inserted load or store whose producer names a live store or barrier is linked to it and is not offered on the ready output, even with its registers ready, until that producer leaves the table.
- R4: A registers-ready command marks the entry, and the entry is offered on the ready output only if it is already memory-ready.
- R5: The producer is chosen in this order. A load takes the most recent full-barrier number while the load-barrier flag is set. A store takes the most recent barrier number while the store-barrier flag is set. Otherwise the predictor input is used. A full barrier sets both flags, and a write barrier sets only the store flag.
- R6: Completing a store or barrier frees its entry. Each linked dependent that has its registers ready goes to the ready output. Each other linked dependent becomes memory-ready.
- R7: Completing a barrier clears a barrier flag only when the number recorded for that flag equals the completing barrier's number.
- R8: A reschedule parks an entry. A replay sends every parked entry to the ready output and empties the parked set, so a second replay has no effect.
- R9: A squash with number S and thread T removes every entry of thread T whose sequence number is greater than S (unsigned), including parked ones. Any surviving entry linked to a removed producer becomes memory-ready.
- R10: At most one entry is offered per cycle. The entry offered is the smallest sequence number among those ready. It is held unchanged until rdy_ready is high at a clock edge, which removes it from the ready set.
- R11: full is high while all table entries are live. An insert while full is ignored and leaves no entry.
- R12: A registers-ready, complete or reschedule command naming a sequence number not in the table changes no state and raises err for exactly the next cycle. err is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_seq | input | SEQ_W | Sequence number the command refers to |
| cmd_tid | input | TID_W | Thread of the inserted entry or of the squash |
| cmd_kind | input | 2 | Kind of the inserted entry |
| cmd_regs_ready | input | 1 | Registers already ready at insert |
| pred_seq | input | SEQ_W | Predicted producing store number, zero for none |
| full | output | 1 | Every table entry is live |
| err | output | 1 | Previous command named an absent sequence number |
| rdy_valid | output | 1 | An entry is offered to issue |
| rdy_seq | output | SEQ_W | Sequence number of the offered entry |
| rdy_ready | input | 1 | Issue side accepts the offered entry |

## Verification
Every internal fault in this block surfaces on four outputs, each of which depends only on registered state. A lost link, a stale memory-ready bit or a wrong barrier flag changes which sequence number appears on rdy_seq. It can also change whether rdy_valid rises. This shows in the cycle after the command that should have woken or blocked the entry. A corrupted occupancy or lookup shows as a wrong full or err level one cycle after the command. The reference model is therefore compared against all four outputs on every cycle, so a divergence is caught at the first cycle it becomes visible rather than at the end of a scenario.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

    typedef enum logic [1:0] {
        MK_LOAD      = 2'd0,
        MK_STORE     = 2'd1,
        MK_FENCE_ALL = 2'd2,
        MK_FENCE_WR  = 2'd3
    } mkind_e;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_INSERT = 3'd1,
        OP_REGS   = 3'd2,
        OP_DONE   = 3'd3,
        OP_PARK   = 3'd4,
        OP_REPLAY = 3'd5,
        OP_SQUASH = 3'd6
    } mop_e;

    function automatic logic is_fence(mkind_e k);
        return (k == MK_FENCE_ALL) || (k == MK_FENCE_WR);
    endfunction

    function automatic logic can_produce(mkind_e k);
        return k != MK_LOAD;
    endfunction

endpackage

// File: rtl/memdep_seq_cam.sv
module memdep_seq_cam #(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0][SEQ_W-1:0] seqs,
    input  logic [N-1:0]            elig,
    input  logic [SEQ_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [N-1:0] match;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign match[g] = elig[g] && (seqs[g] == key);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/memdep_free_find.sv
module memdep_free_find #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     busy,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    assign any_free = ~&busy;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/memdep_oldest_pick.sv
module memdep_oldest_pick #(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]            req,
    input  logic [N-1:0][SEQ_W-1:0] seqs,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || seqs[i] < best)) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = seqs[i];
            end
        end
    end
endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
    import memdep_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int SEQ_W   = 16,
    parameter int THREADS = 2,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic [TID_W-1:0] cmd_tid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_regs_ready,
    input  logic [SEQ_W-1:0] pred_seq,
    output logic             full,
    output logic             err,
    output logic             rdy_valid,
    output logic [SEQ_W-1:0] rdy_seq,
    input  logic             rdy_ready
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             live;
        logic [SEQ_W-1:0] seq;
        logic [TID_W-1:0] tid;
        mkind_e           kind;
        logic             regs;
        logic             memr;
        logic             link;
        logic [IDX_W-1:0] prod;
        logic             pend;
        logic             parked;
    } ent_t;

    ent_t tbl_q [ENTRIES];
    ent_t tbl_d [ENTRIES];

    logic             lb_q, lb_d, sb_q, sb_d;
    logic [SEQ_W-1:0] lbs_q, lbs_d, sbs_q, sbs_d;
    logic             err_q, err_d;

    mop_e   op;
    mkind_e kind_in;
    assign op      = mop_e'(cmd_op);
    assign kind_in = mkind_e'(cmd_kind);

    logic [ENTRIES-1:0][SEQ_W-1:0] seq_flat;
    logic [ENTRIES-1:0]            live_vec;
    logic [ENTRIES-1:0]            prod_vec;
    logic [ENTRIES-1:0]            pend_vec;
    logic [ENTRIES-1:0]            memr_vec;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            seq_flat[i] = tbl_q[i].seq;
            live_vec[i] = tbl_q[i].live;
            prod_vec[i] = tbl_q[i].live && can_produce(tbl_q[i].kind);
            pend_vec[i] = tbl_q[i].pend;
            memr_vec[i] = tbl_q[i].memr;
        end
    end

    // producer selection: outstanding barriers win over the predictor
    logic [SEQ_W-1:0] pick_seq;
    always_comb begin
        if (kind_in == MK_LOAD && lb_q)       pick_seq = lbs_q;
        else if (kind_in == MK_STORE && sb_q) pick_seq = sbs_q;
        else                                  pick_seq = pred_seq;
    end

    logic             cmd_hit, prod_cam_hit, prod_hit, free_any, pick_any;
    logic [IDX_W-1:0] cmd_idx, prod_idx, free_idx, pick_idx;

    memdep_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_cmd_cam (
        .seqs(seq_flat), .elig(live_vec), .key(cmd_seq),
        .hit(cmd_hit), .idx(cmd_idx)
    );

    memdep_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_prod_cam (
        .seqs(seq_flat), .elig(prod_vec), .key(pick_seq),
        .hit(prod_cam_hit), .idx(prod_idx)
    );

    assign prod_hit = prod_cam_hit && (pick_seq != '0);

    memdep_free_find #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
        .busy(live_vec), .any_free(free_any), .idx(free_idx)
    );

    memdep_oldest_pick #(.N(ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
        .req(pend_vec), .seqs(seq_flat), .any(pick_any), .idx(pick_idx)
    );

    assign full      = !free_any;
    assign err       = err_q;
    assign rdy_valid = pick_any;
    assign rdy_seq   = tbl_q[pick_idx].seq;

    logic pop;
    assign pop = pick_any && rdy_ready;

    logic [ENTRIES-1:0] kill;

    always_comb begin
        tbl_d = tbl_q;
        lb_d  = lb_q;
        sb_d  = sb_q;
        lbs_d = lbs_q;
        sbs_d = sbs_q;
        err_d = 1'b0;
        kill  = '0;

        if (pop) tbl_d[pick_idx].pend = 1'b0;

        if (cmd_valid) begin
            case (op)
                OP_INSERT: begin
                    if (free_any) begin
                        tbl_d[free_idx]      = '0;
                        tbl_d[free_idx].live = 1'b1;
                        tbl_d[free_idx].seq  = cmd_seq;
                        tbl_d[free_idx].tid  = cmd_tid;
                        tbl_d[free_idx].kind = kind_in;
                        tbl_d[free_idx].regs = cmd_regs_ready;
                        if (is_fence(kind_in)) begin
                            sb_d  = 1'b1;
                            sbs_d = cmd_seq;
                            if (kind_in == MK_FENCE_ALL) begin
                                lb_d  = 1'b1;
                                lbs_d = cmd_seq;
                            end
                        end else if (prod_hit) begin
                            tbl_d[free_idx].link = 1'b1;
                            tbl_d[free_idx].prod = prod_idx;
                        end else begin
                            tbl_d[free_idx].memr = 1'b1;
                            tbl_d[free_idx].pend = cmd_regs_ready;
                        end
                    end
                end
                OP_REGS: begin
                    if (cmd_hit) begin
                        tbl_d[cmd_idx].regs = 1'b1;
                        if (tbl_q[cmd_idx].memr && !is_fence(tbl_q[cmd_idx].kind))
                            tbl_d[cmd_idx].pend = 1'b1;
                    end else begin
                        err_d = 1'b1;
                    end
                end
                OP_DONE: begin
                    if (cmd_hit) begin
                        kill[cmd_idx] = 1'b1;
                        if (tbl_q[cmd_idx].kind == MK_FENCE_ALL) begin
                            if (lbs_q == cmd_seq) lb_d = 1'b0;
                            if (sbs_q == cmd_seq) sb_d = 1'b0;
                        end else if (tbl_q[cmd_idx].kind == MK_FENCE_WR) begin
                            if (sbs_q == cmd_seq) sb_d = 1'b0;
                        end
                    end else begin
                        err_d = 1'b1;
                    end
                end
                OP_PARK: begin
                    if (cmd_hit) tbl_d[cmd_idx].parked = 1'b1;
                    else         err_d = 1'b1;
                end
                OP_REPLAY: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (tbl_q[i].parked) begin
                            tbl_d[i].pend   = 1'b1;
                            tbl_d[i].parked = 1'b0;
                        end
                    end
                end
                OP_SQUASH: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (tbl_q[i].live && tbl_q[i].tid == cmd_tid &&
                            tbl_q[i].seq > cmd_seq)
                            kill[i] = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // free removed entries
        for (int i = 0; i < ENTRIES; i++) begin
            if (kill[i]) begin
                tbl_d[i].live   = 1'b0;
                tbl_d[i].pend   = 1'b0;
                tbl_d[i].parked = 1'b0;
                tbl_d[i].link   = 1'b0;
            end
        end

        // wake every survivor whose producer left the table
        for (int i = 0; i < ENTRIES; i++) begin
            if (tbl_d[i].live && tbl_d[i].link && kill[tbl_d[i].prod]) begin
                tbl_d[i].link = 1'b0;
                tbl_d[i].memr = 1'b1;
                if (tbl_d[i].regs) tbl_d[i].pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
            lb_q  <= 1'b0;
            sb_q  <= 1'b0;
            lbs_q <= '0;
            sbs_q <= '0;
            err_q <= 1'b0;
        end else begin
            tbl_q <= tbl_d;
            lb_q  <= lb_d;
            sb_q  <= sb_d;
            lbs_q <= lbs_d;
            sbs_q <= sbs_d;
            err_q <= err_d;
        end
    end
endmodule

// File: rtl/memdep_tracker_chk.sv
module memdep_tracker_chk #(
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [SEQ_W-1:0] cmd_seq,
    input logic             cmd_hit,
    input logic             full,
    input logic             err,
    input logic             rdy_valid,
    input logic [SEQ_W-1:0] rdy_seq,
    input logic             rdy_ready
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rdy_valid && !err && !full));

    assert_insert_full_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd1 && full) |=> full);

    assert_err_only_after_lookup_R12: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4)) |=> !err);

    assert_offer_held_R10: assert property (@(posedge clk) disable iff (rst)
        (rdy_valid && !rdy_ready && !cmd_valid) |=> (rdy_valid && $stable(rdy_seq)));

    assert_done_frees_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd3 && cmd_hit) |=>
            !(rdy_valid && rdy_seq == $past(cmd_seq)));
endmodule

bind memdep_tracker memdep_tracker_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_seq(cmd_seq), .cmd_hit(cmd_hit), .full(full), .err(err),
    .rdy_valid(rdy_valid), .rdy_seq(rdy_seq), .rdy_ready(rdy_ready)
);

// File: tb/memdep_tracker_tb.sv
`timescale 1ns/1ps
module memdep_tracker_tb;
    localparam int N  = 16;
    localparam int MS = 256;
    localparam int IDLE = 0, INS = 1, REGS = 2, DONE = 3, PARK = 4, REPLAY = 5, SQ = 6;
    localparam int KL = 0, KS = 1, KFA = 2, KFW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_seq = '0;
    logic        cmd_tid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic        cmd_regs_ready = 1'b0;
    logic [15:0] pred_seq = '0;
    logic        rdy_ready = 1'b0;
    logic        full, err, rdy_valid;
    logic [15:0] rdy_seq;

    always #2.5 clk = ~clk;

    memdep_tracker u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_seq(cmd_seq), .cmd_tid(cmd_tid), .cmd_kind(cmd_kind),
        .cmd_regs_ready(cmd_regs_ready), .pred_seq(pred_seq),
        .full(full), .err(err), .rdy_valid(rdy_valid), .rdy_seq(rdy_seq),
        .rdy_ready(rdy_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model indexed by sequence number
    bit m_live [MS];
    int m_kind [MS];
    int m_tid  [MS];
    bit m_regs [MS];
    bit m_memr [MS];
    int m_prod [MS];
    bit m_pend [MS];
    bit m_park [MS];
    int m_cnt;
    bit m_lb, m_sb, m_err;
    int m_lbs, m_sbs;

    function automatic int first_pend();
        for (int s = 0; s < MS; s++) if (m_pend[s]) return s;
        return -1;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check(string tag);
        int fp;
        fp = first_pend();
        cmp(tag, "rdy_valid", int'(rdy_valid), (fp >= 0) ? 1 : 0);
        if (fp >= 0) cmp(tag, "rdy_seq", int'(rdy_seq), fp);
        cmp(tag, "full", int'(full), (m_cnt == N) ? 1 : 0);
        cmp(tag, "err", int'(err), int'(m_err));
    endtask

    task automatic remove_set(bit k [MS]);
        for (int s = 0; s < MS; s++) begin
            if (k[s]) begin
                m_live[s] = 0; m_pend[s] = 0; m_park[s] = 0; m_prod[s] = -1;
                m_cnt--;
            end
        end
        for (int s = 0; s < MS; s++) begin
            if (m_live[s] && m_prod[s] >= 0 && k[m_prod[s]]) begin
                m_prod[s] = -1;
                m_memr[s] = 1;
                if (m_regs[s]) m_pend[s] = 1;
            end
        end
    endtask

    task automatic model_apply(int op, int seq, int tid, int kind, bit regs, int pred, bit rr);
        int fp, p;
        bit k [MS];
        for (int s = 0; s < MS; s++) k[s] = 0;
        m_err = 0;
        fp = first_pend();
        if (rr && fp >= 0) m_pend[fp] = 0;
        case (op)
            INS: if (m_cnt < N) begin
                m_live[seq] = 1; m_cnt++;
                m_kind[seq] = kind; m_tid[seq] = tid; m_regs[seq] = regs;
                m_memr[seq] = 0; m_prod[seq] = -1; m_pend[seq] = 0; m_park[seq] = 0;
                if (kind == KFA) begin
                    m_lb = 1; m_lbs = seq; m_sb = 1; m_sbs = seq;
                end else if (kind == KFW) begin
                    m_sb = 1; m_sbs = seq;
                end else begin
                    p = (kind == KL && m_lb) ? m_lbs : ((kind == KS && m_sb) ? m_sbs : pred);
                    if (p != 0 && p < MS && m_live[p] && m_kind[p] != KL) m_prod[seq] = p;
                    else begin m_memr[seq] = 1; m_pend[seq] = regs; end
                end
            end
            REGS: if (!m_live[seq]) m_err = 1;
                  else begin
                      m_regs[seq] = 1;
                      if (m_memr[seq] && m_kind[seq] < KFA) m_pend[seq] = 1;
                  end
            DONE: if (!m_live[seq]) m_err = 1;
                  else begin
                      if (m_kind[seq] == KFA) begin
                          if (m_lbs == seq) m_lb = 0;
                          if (m_sbs == seq) m_sb = 0;
                      end else if (m_kind[seq] == KFW) begin
                          if (m_sbs == seq) m_sb = 0;
                      end
                      k[seq] = 1;
                      remove_set(k);
                  end
            PARK: if (!m_live[seq]) m_err = 1; else m_park[seq] = 1;
            REPLAY: for (int s = 0; s < MS; s++)
                        if (m_park[s]) begin m_pend[s] = 1; m_park[s] = 0; end
            SQ: begin
                for (int s = 0; s < MS; s++)
                    if (m_live[s] && m_tid[s] == tid && s > seq) k[s] = 1;
                remove_set(k);
            end
            default: ;
        endcase
    endtask

    task automatic step(string tag, int op, int seq, int tid, int kind, bit regs, int pred, bit rr);
        @(negedge clk);
        check(tag);
        cmd_valid      = (op != IDLE);
        cmd_op         = 3'(op);
        cmd_seq        = 16'(seq);
        cmd_tid        = 1'(tid);
        cmd_kind       = 2'(kind);
        cmd_regs_ready = regs;
        pred_seq       = 16'(pred);
        rdy_ready      = rr;
        model_apply(op, seq, tid, kind, regs, pred, rr);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < MS; s++) begin
            m_live[s] = 0; m_pend[s] = 0; m_park[s] = 0; m_prod[s] = -1;
            m_kind[s] = 0; m_tid[s] = 0; m_regs[s] = 0; m_memr[s] = 0;
        end
        m_cnt = 0; m_lb = 0; m_sb = 0; m_lbs = 0; m_sbs = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        step("R1", IDLE, 0, 0, 0, 0, 0, 0);
        step("R1", IDLE, 0, 0, 0, 0, 0, 1);
        // R10 hold while not accepted
        step("R10", INS, 10, 0, KL, 1, 0, 0);
        step("R10", IDLE, 0, 0, 0, 0, 0, 0);
        step("R10", IDLE, 0, 0, 0, 0, 0, 0);
        step("R10", IDLE, 0, 0, 0, 0, 0, 1);
        step("R10", IDLE, 0, 0, 0, 0, 0, 1);
        // R2 / R3 dependences through the predictor
        step("R2", INS, 20, 0, KS, 1, 0, 1);
        step("R3", INS, 30, 0, KL, 1, 20, 1);
        step("R3", INS, 31, 0, KL, 0, 20, 1);
        step("R2", INS, 32, 0, KL, 1, 99, 1);
        step("R3", IDLE, 0, 0, 0, 0, 0, 1);
        step("R3", IDLE, 0, 0, 0, 0, 0, 1);
        // R6 store completion wakes
        step("R6", DONE, 20, 0, 0, 0, 0, 0);
        step("R6", IDLE, 0, 0, 0, 0, 0, 1);
        step("R4", REGS, 31, 0, 0, 0, 0, 0);
        step("R4", IDLE, 0, 0, 0, 0, 0, 1);
        step("R4", INS, 33, 0, KL, 0, 0, 1);
        step("R2", INS, 34, 0, KL, 1, 10, 1);
        step("R4", REGS, 33, 0, 0, 0, 0, 1);
        step("R4", IDLE, 0, 0, 0, 0, 0, 1);
        step("R4", IDLE, 0, 0, 0, 0, 0, 1);
        // R5 barrier precedence
        step("R5", INS, 40, 0, KFW, 0, 0, 0);
        step("R5", INS, 41, 0, KL, 1, 0, 0);
        step("R5", INS, 42, 0, KS, 1, 0, 0);
        step("R5", INS, 50, 0, KFA, 0, 0, 0);
        step("R5", INS, 51, 0, KL, 1, 0, 0);
        step("R5", INS, 60, 0, KFW, 0, 0, 0);
        step("R5", INS, 61, 0, KS, 1, 0, 0);
        step("R5", IDLE, 0, 0, 0, 0, 0, 1);
        step("R5", IDLE, 0, 0, 0, 0, 0, 1);
        // R7 flag cleared only by the latest barrier
        step("R7", DONE, 50, 0, 0, 0, 0, 0);
        step("R7", INS, 62, 0, KS, 1, 0, 0);
        step("R7", INS, 63, 0, KL, 1, 0, 0);
        step("R7", IDLE, 0, 0, 0, 0, 0, 1);
        step("R7", IDLE, 0, 0, 0, 0, 0, 1);
        step("R7", DONE, 40, 0, 0, 0, 0, 0);
        step("R7", IDLE, 0, 0, 0, 0, 0, 1);
        step("R7", DONE, 60, 0, 0, 0, 0, 0);
        step("R10", IDLE, 0, 0, 0, 0, 0, 1);
        step("R10", IDLE, 0, 0, 0, 0, 0, 1);
        step("R10", IDLE, 0, 0, 0, 0, 0, 1);
        step("R7", INS, 64, 0, KS, 1, 0, 1);
        step("R7", IDLE, 0, 0, 0, 0, 0, 1);
        // R8 reschedule and replay
        step("R8", PARK, 30, 0, 0, 0, 0, 1);
        step("R8", PARK, 32, 0, 0, 0, 0, 1);
        step("R8", IDLE, 0, 0, 0, 0, 0, 1);
        step("R8", REPLAY, 0, 0, 0, 0, 0, 0);
        step("R8", IDLE, 0, 0, 0, 0, 0, 1);
        step("R8", IDLE, 0, 0, 0, 0, 0, 1);
        step("R8", REPLAY, 0, 0, 0, 0, 0, 1);
        step("R8", IDLE, 0, 0, 0, 0, 0, 1);
        step("R8", IDLE, 0, 0, 0, 0, 0, 1);
        // R9 squash
        step("R9", INS, 100, 1, KS, 1, 0, 1);
        step("R9", INS, 101, 1, KL, 1, 100, 1);
        step("R9", INS, 102, 0, KL, 0, 100, 1);
        step("R9", INS, 103, 1, KL, 1, 0, 1);
        step("R9", PARK, 103, 1, 0, 0, 0, 1);
        step("R9", SQ, 99, 1, 0, 0, 0, 1);
        step("R9", REGS, 102, 0, 0, 0, 0, 0);
        step("R9", REGS, 101, 0, 0, 0, 0, 0);
        step("R9", REPLAY, 0, 0, 0, 0, 0, 0);
        step("R9", IDLE, 0, 0, 0, 0, 0, 1);
        step("R9", IDLE, 0, 0, 0, 0, 0, 1);
        // R12 lookups of absent numbers
        step("R12", DONE, 77, 0, 0, 0, 0, 1);
        step("R12", IDLE, 0, 0, 0, 0, 0, 1);
        step("R12", PARK, 77, 0, 0, 0, 0, 1);
        step("R12", IDLE, 0, 0, 0, 0, 0, 1);
        // R11 fill the table
        for (int i = 0; i < 20; i++) step("R11", INS, 150 + i, 0, KL, 0, 0, 1);
        step("R11", REGS, 169, 0, 0, 0, 0, 1);
        step("R11", DONE, 150, 0, 0, 0, 0, 1);
        step("R11", INS, 170, 0, KL, 1, 0, 0);
        step("R11", IDLE, 0, 0, 0, 0, 0, 0);
        step("R9", SQ, 0, 0, 0, 0, 0, 0);
        step("R9", SQ, 0, 1, 0, 0, 0, 0);
        step("R9", IDLE, 0, 0, 0, 0, 0, 1);
        step("R1", IDLE, 0, 0, 0, 0, 0, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule